// File: doc/BRIEF.md
# Three-pin tri-state GPIO port with analog masking

This block is a small bidirectional general-purpose I/O port that sits on a simple synchronous register bus. Each of its three pins is set up on its own as a driven output or a released input. An output pin drives the value held in the output data latch. An input pin has its driver turned off.

Software sees three 8-bit registers: a pin register, a latch register and a direction register. A write to the pin register or the latch register loads the output latch. A read of the latch register returns the stored latch value. A read of the pin register returns the synchronized level on the pads. A read of the direction register returns the direction bits. The bits above the three pin bits always read as zero.

An external analog-select vector marks pins that are routed to an analog converter. Those pins read as zero through the pin register. The direction bits still control the drivers of those pins. Keeping an analog pin as an input is left to software.

Top module: `gpio_tri_port`

## Requirements
- R1: After reset every direction bit is 1, so `pad_oe` is 000. The output latch is 000 and `bus_rdata` is 0x00.
- R2: A direction bit of 0 drives `pad_oe` high for that pin, and a direction bit of 1 drives it low. `pad_out` always shows the latch bits.
- R3: A write to address 0 (pin register) or address 1 (latch register) loads `bus_wdata[2:0]` into the latch. The new value appears on `pad_out` after the write clock edge.
- R4: A read of address 1 returns the latch value in bits [2:0], not the pin levels.
- R5: A read of address 0 returns the pad levels through a two-flop synchronizer. The value seen by a read at clock edge k is the one `pad_in` held at edge k-2.
- R6: A pin whose `ana_sel` bit is 1 at the read edge reads as 0 through address 0. Reads through address 1 are not affected.
- R7: `ana_sel` has no effect on `pad_oe` or `pad_out`. The direction bits keep control of the drivers while a pin is in analog mode.
- R8: Address 2 is the direction register and can be both read and written. In every read, bits [7:3] of `bus_rdata` are 0.
- R9: Address 3 reads as 0x00. A write to address 3 changes neither the latch nor the direction bits.
- R10: `bus_rdata` is registered and is loaded only on a clock edge where `bus_re` is 1. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 pin, 1 latch, 2 direction |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| pad_oe | output | 3 | Per-pin driver enable (1 = drive) |
| pad_out | output | 3 | Per-pin drive value |
| pad_in | input | 3 | Per-pin level from the pad |
| ana_sel | input | 3 | Per-pin analog-mode select |

## Verification
The assertions assume that the bus inputs are stable around the clock edge and free of X whenever `bus_we` or `bus_re` is high. They also assume that `ana_sel` is defined at every read edge. The bench changes all inputs only on the falling clock edge and always drives a defined value on each one, including `pad_in`. The reference model depends on the synchronizer delay, so the bench holds `pad_in` at zero during reset, where the synchronizer flops are also cleared.

// File: rtl/gpio_tri_port.sv
module gpio_tri_port #(
  parameter int NPIN = 3,
  parameter int AW   = 2,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] ana_sel
);
  localparam logic [AW-1:0] A_PIN = AW'(0);
  localparam logic [AW-1:0] A_LAT = AW'(1);
  localparam logic [AW-1:0] A_DIR = AW'(2);
  localparam int PAD = DW - NPIN;

  logic [NPIN-1:0] dir_q, lat_q, sync1_q, sync2_q, rsel;

  assign pad_oe  = ~dir_q;
  assign pad_out = lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '1;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_we && (bus_addr == A_PIN || bus_addr == A_LAT))
        lat_q <= bus_wdata[NPIN-1:0];
      if (bus_we && bus_addr == A_DIR)
        dir_q <= bus_wdata[NPIN-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_PIN:   rsel = sync2_q & ~ana_sel;
      A_LAT:   rsel = lat_q;
      A_DIR:   rsel = dir_q;
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= {{PAD{1'b0}}, rsel};
  end

  // R2
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> pad_oe == ~$past(bus_wdata[NPIN-1:0]));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_PIN || bus_addr == A_LAT)) |=> pad_out == $past(bus_wdata[NPIN-1:0]));

  // R6
  analog_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_PIN) |=> (bus_rdata[NPIN-1:0] & $past(ana_sel)) == '0);

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rdata[DW-1:NPIN] == '0);

  // R9
  bad_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3)) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_tri_port_bench.sv
module gpio_tri_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] pad_oe, pad_out;
  logic [2:0] pad_in = '0, ana_sel = '0;

  int n_run = 0, n_fail = 0;
  int m_dir, m_lat, m_rd;
  int pin_hist[$];
  bit done = 0;

  always #2 clk = ~clk;

  gpio_tri_port u_gpio_tri_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in), .ana_sel(ana_sel));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(string req, int a, int wd, bit we, bit re, int pin, int ana);
    int old_pin, nrd;
    bus_addr = 2'(a); bus_wdata = 8'(wd); bus_we = we; bus_re = re;
    pad_in = 3'(pin); ana_sel = 3'(ana);
    @(posedge clk);
    pin_hist.push_back(pin);
    old_pin = pin_hist[pin_hist.size()-3];
    nrd = m_rd;
    if (re) begin
      if (a == 0)      nrd = old_pin & ~ana & 7;
      else if (a == 1) nrd = m_lat;
      else if (a == 2) nrd = m_dir;
      else             nrd = 0;
    end
    m_rd = nrd;
    if (we && (a == 0 || a == 1)) m_lat = wd & 7;
    if (we && a == 2) m_dir = wd & 7;
    @(negedge clk);
    chk({req, " pad_oe"}, pad_oe, ~m_dir & 7);
    chk({req, " pad_out"}, pad_out, m_lat);
    chk({req, " rdata"}, bus_rdata, m_rd);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int pin;
    m_dir = 7; m_lat = 0; m_rd = 0;
    repeat (3) pin_hist.push_back(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 rdata", bus_rdata, 0);
    step("R8 read dir", 2, 0, 0, 1, 0, 0);
    chk("R8 dir reset", bus_rdata, 8'h07);
    step("R3 write latch", 1, 8'hF5, 1, 0, 0, 0);
    step("R4 read latch", 1, 0, 0, 1, 0, 0);
    chk("R4 latch 5", bus_rdata, 5);
    step("R3 write via pin addr", 0, 8'hFA, 1, 0, 0, 0);
    step("R4 read latch", 1, 0, 0, 1, 0, 0);
    chk("R4 latch 2", bus_rdata, 2);
    step("R2 dir write", 2, 8'h02, 1, 0, 0, 0);
    chk("R2 pad_oe 101", pad_oe, 3'b101);
    step("R8 read dir", 2, 0, 0, 1, 0, 0);
    // R5 pin levels through synchronizer
    step("R5 pins", 3, 0, 0, 0, 3'b101, 0);
    step("R5 pins", 3, 0, 0, 0, 3'b101, 0);
    step("R5 read", 0, 0, 0, 1, 3'b011, 0);
    chk("R5 read 101", bus_rdata, 3'b101);
    step("R5 stale read", 0, 0, 0, 1, 3'b011, 0);
    step("R5 read", 0, 0, 0, 1, 3'b011, 0);
    chk("R5 read 011", bus_rdata, 3'b011);
    step("R4 latch not pins", 1, 0, 0, 1, 3'b111, 0);
    // R6 analog masking
    step("R6 read", 0, 0, 0, 1, 3'b111, 3'b001);
    step("R6 read", 0, 0, 0, 1, 3'b111, 3'b001);
    step("R6 read", 0, 0, 0, 1, 3'b111, 3'b001);
    chk("R6 masked", bus_rdata, 3'b110);
    step("R6 latch unmasked", 1, 0, 0, 1, 3'b111, 3'b111);
    // R7 direction still controls drivers under analog select
    step("R7 dir 0", 2, 0, 1, 0, 3'b111, 3'b111);
    chk("R7 pad_oe", pad_oe, 3'b111);
    step("R7 latch", 1, 7, 1, 0, 3'b111, 3'b111);
    chk("R7 pad_out", pad_out, 3'b111);
    // R9 unused address
    step("R9 write addr3", 3, 8'hFF, 1, 0, 0, 0);
    step("R9 write addr3", 3, 8'h00, 1, 1, 0, 0);
    chk("R9 read 0", bus_rdata, 0);
    chk("R9 latch kept", pad_out, 7);
    // R10 hold
    step("R10 idle", 2, 8'h05, 1, 0, 0, 0);
    step("R10 idle", 1, 0, 0, 0, 3, 0);
    chk("R10 hold", bus_rdata, 0);
    for (int i = 0; i < 400; i++) begin
      pin = $urandom_range(0, 7);
      step("R2-mix", $urandom_range(0, 3), $urandom_range(0, 255),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pin, $urandom_range(0, 7));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule